// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Summary Shortcuts

This block collects 72 level-sensitive interrupt lines and drives one IRQ line and one FIQ line. The lines fall into three groups: 8 local lines and two peripheral banks of 32 lines each. Every line passes through a two-flop synchroniser. It is then masked by its own enable bit. Software changes enables only by writing ones to a set address or to a clear address. Bits written as zero leave the enable state alone.

A 32-bit register port shows the masked pending state of each bank. It also offers a summary word that software can read first. The summary word carries:
- the local lines;
- one "something else pending" flag per bank;
- direct copies of eleven frequently used bank lines, so that software can often find its source with one read.

A small control register can route one chosen source to the FIQ line instead of the IRQ line.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Register byte offsets are as follows:
  - 0x00 is the summary.
  - 0x04 and 0x08 are the bank-1 and bank-2 masked pending words.
  - 0x0C is the FIQ control.
  - 0x10, 0x14 and 0x18 set enables for bank 1, bank 2 and the local lines.
  - 0x1C, 0x20 and 0x24 clear enables for bank 1, bank 2 and the local lines.
  - A read of a set or clear address returns the current enable word of that group.
  - Any other address reads zero.
- R2: A write to a set address turns on the enable of every bit written as 1. A write to a clear address turns off the enable of every bit written as 1. Bits written as 0 keep their state. The new state is readable in the cycle after the write edge.
- R3: A bank pending word bit is 1 exactly when its synchronised input is high and its enable is set.
- R4: Summary bits 7:0 are the masked pending state of local lines 0 to 7.
- R5: Summary bits 14:10 copy masked pending bank-1 bits 7, 9, 10, 18 and 19, in that order. Summary bits 20:15 copy masked pending bank-2 bits 21, 22, 23, 24, 25 and 30, in that order. Summary bits 31:21 read zero.
- R6: Summary bit 8 is 1 when any masked pending bank-1 bit outside the bank-1 shortcut set is 1. Summary bit 9 is the same for bank 2 and its shortcut set.
- R7: irq_o is the OR of all masked pending sources, leaving out the source currently routed to FIQ.
- R8: FIQ control bits 6:0 pick a global source number. Local line n is number n, bank-1 bit n is 8+n, and bank-2 bit n is 40+n. Bit 7 turns routing on. While routing is on, fiq_o follows the masked pending state of the picked source. A number of 72 or more picks nothing. The register reads back its 8 bits.
- R9: After reset all enables are 0, the FIQ control is 0, and both outputs are low.
- R10: An input change reaches the pending state after exactly two clock edges. A pending bit clears again when its input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_local | input | 8 | Local interrupt lines, level high |
| src_bank1 | input | 32 | Bank-1 interrupt lines, level high |
| src_bank2 | input | 32 | Bank-2 interrupt lines, level high |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle, the embedded properties check three things:
- the set and clear semantics of each enable group, including that unwritten bits hold;
- that the FIQ line is only driven while routing is on;
- that an IRQ is never raised without a matching summary bit.

Only the bench scenarios can show:
- the exact summary bit placement of each shortcut;
- the exclusion of shortcut lines from the bank flags;
- the two-edge synchroniser latency;
- the global numbering used by the FIQ selector, including the out-of-range index.

// File: rtl/bic_pkg.sv
package bic_pkg;
   localparam int NUM_LOCAL = 8;
   localparam int BANK_W    = 32;
   localparam int NUM_SRC   = NUM_LOCAL + 2 * BANK_W;
   localparam int N_SC1     = 5;
   localparam int N_SC2     = 6;
   // Shortcut positions; order sets the summary bit order.
   localparam int SC1_POS [N_SC1] = '{7, 9, 10, 18, 19};
   localparam int SC2_POS [N_SC2] = '{21, 22, 23, 24, 25, 30};
   localparam int SUM_B1_FLAG = NUM_LOCAL;
   localparam int SUM_B2_FLAG = NUM_LOCAL + 1;
   localparam int SUM_SC1_LO  = NUM_LOCAL + 2;
   localparam int SUM_SC2_LO  = SUM_SC1_LO + N_SC1;

   localparam logic [7:0] OFS_SUM   = 8'h00;
   localparam logic [7:0] OFS_PB1   = 8'h04;
   localparam logic [7:0] OFS_PB2   = 8'h08;
   localparam logic [7:0] OFS_FIQ   = 8'h0C;
   localparam logic [7:0] OFS_SETB1 = 8'h10;
   localparam logic [7:0] OFS_SETB2 = 8'h14;
   localparam logic [7:0] OFS_SETL  = 8'h18;
   localparam logic [7:0] OFS_CLRB1 = 8'h1C;
   localparam logic [7:0] OFS_CLRB2 = 8'h20;
   localparam logic [7:0] OFS_CLRL  = 8'h24;

   function automatic logic [BANK_W-1:0] sc1_mask();
      logic [BANK_W-1:0] m = '0;
      for (int k = 0; k < N_SC1; k++) m[SC1_POS[k]] = 1'b1;
      return m;
   endfunction

   function automatic logic [BANK_W-1:0] sc2_mask();
      logic [BANK_W-1:0] m = '0;
      for (int k = 0; k < N_SC2; k++) m[SC2_POS[k]] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad
      $error("bic_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bic_enable.sv
module bic_enable #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q[i] <= 1'b0;
         else if (set_we && wdata[i]) en_q[i] <= 1'b1;
         else if (clr_we && wdata[i]) en_q[i] <= 1'b0;
      end
   end

   p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
   p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((en_q & $past(wdata)) == '0));
   p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we || clr_we) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/bic_summary.sv
module bic_summary
   import bic_pkg::*;
(
   input  logic [NUM_LOCAL-1:0] pend_local,
   input  logic [BANK_W-1:0]    pend_b1,
   input  logic [BANK_W-1:0]    pend_b2,
   output logic [31:0]          summary
);
   localparam logic [BANK_W-1:0] M1 = sc1_mask();
   localparam logic [BANK_W-1:0] M2 = sc2_mask();

   if (SUM_SC2_LO + N_SC2 > 32) begin : g_bad
      $error("summary layout exceeds 32 bits");
   end

   logic [N_SC1-1:0] sc1;
   logic [N_SC2-1:0] sc2;

   for (genvar k = 0; k < N_SC1; k++) begin : g_sc1
      assign sc1[k] = pend_b1[SC1_POS[k]];
   end
   for (genvar k = 0; k < N_SC2; k++) begin : g_sc2
      assign sc2[k] = pend_b2[SC2_POS[k]];
   end

   always_comb begin
      summary = '0;
      summary[NUM_LOCAL-1:0]                 = pend_local;
      summary[SUM_B1_FLAG]                   = |(pend_b1 & ~M1);
      summary[SUM_B2_FLAG]                   = |(pend_b2 & ~M2);
      summary[SUM_SC1_LO +: N_SC1]           = sc1;
      summary[SUM_SC2_LO +: N_SC2]           = sc2;
   end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import bic_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LOCAL-1:0] src_local,
   input  logic [BANK_W-1:0]    src_bank1,
   input  logic [BANK_W-1:0]    src_bank2,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic                 irq_o,
   output logic                 fiq_o
);
   localparam int IDX_W = $clog2(NUM_SRC);

   if (ADDR_W < 6) begin : g_bad_aw
      $error("address too narrow for register map");
   end
   if (BANK_W != 32 || NUM_LOCAL > 8 || IDX_W > 7) begin : g_bad_geom
      $error("register layout assumes 32-bit banks");
   end

   localparam logic [ADDR_W-1:0] A_SUM   = ADDR_W'(OFS_SUM);
   localparam logic [ADDR_W-1:0] A_PB1   = ADDR_W'(OFS_PB1);
   localparam logic [ADDR_W-1:0] A_PB2   = ADDR_W'(OFS_PB2);
   localparam logic [ADDR_W-1:0] A_FIQ   = ADDR_W'(OFS_FIQ);
   localparam logic [ADDR_W-1:0] A_SETB1 = ADDR_W'(OFS_SETB1);
   localparam logic [ADDR_W-1:0] A_SETB2 = ADDR_W'(OFS_SETB2);
   localparam logic [ADDR_W-1:0] A_SETL  = ADDR_W'(OFS_SETL);
   localparam logic [ADDR_W-1:0] A_CLRB1 = ADDR_W'(OFS_CLRB1);
   localparam logic [ADDR_W-1:0] A_CLRB2 = ADDR_W'(OFS_CLRB2);
   localparam logic [ADDR_W-1:0] A_CLRL  = ADDR_W'(OFS_CLRL);

   logic [NUM_SRC-1:0]   raw_s;
   logic [NUM_LOCAL-1:0] en_l;
   logic [BANK_W-1:0]    en_b1, en_b2;
   logic [NUM_LOCAL-1:0] pl;
   logic [BANK_W-1:0]    pb1, pb2;
   logic [31:0]          summary;
   logic [7:0]           fiq_q;
   logic [NUM_SRC-1:0]   all_pend, route_mask;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[31:8];

   bic_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({src_bank2, src_bank1, src_local}), .q(raw_s));

   bic_enable #(.W(NUM_LOCAL)) u_en_l (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_SETL),
      .clr_we(reg_we && reg_addr == A_CLRL),
      .wdata(reg_wdata[NUM_LOCAL-1:0]), .en_q(en_l));

   bic_enable #(.W(BANK_W)) u_en_b1 (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_SETB1),
      .clr_we(reg_we && reg_addr == A_CLRB1),
      .wdata(reg_wdata), .en_q(en_b1));

   bic_enable #(.W(BANK_W)) u_en_b2 (
      .clk(clk), .rst_n(rst_n),
      .set_we(reg_we && reg_addr == A_SETB2),
      .clr_we(reg_we && reg_addr == A_CLRB2),
      .wdata(reg_wdata), .en_q(en_b2));

   assign pl  = raw_s[NUM_LOCAL-1:0] & en_l;
   assign pb1 = raw_s[NUM_LOCAL +: BANK_W] & en_b1;
   assign pb2 = raw_s[NUM_LOCAL + BANK_W +: BANK_W] & en_b2;

   bic_summary u_sum (
      .pend_local(pl), .pend_b1(pb1), .pend_b2(pb2), .summary(summary));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fiq_q <= '0;
      else if (reg_we && reg_addr == A_FIQ) fiq_q <= reg_wdata[7:0];
   end

   assign all_pend   = {pb2, pb1, pl};
   assign route_mask = fiq_q[7] ? (NUM_SRC'(1) << fiq_q[6:0]) : '0;
   assign fiq_o      = |(all_pend & route_mask);
   assign irq_o      = |(all_pend & ~route_mask);

   always_comb begin
      unique case (reg_addr)
         A_SUM:           reg_rdata = summary;
         A_PB1:           reg_rdata = pb1;
         A_PB2:           reg_rdata = pb2;
         A_FIQ:           reg_rdata = {24'd0, fiq_q};
         A_SETB1, A_CLRB1: reg_rdata = en_b1;
         A_SETB2, A_CLRB2: reg_rdata = en_b2;
         A_SETL, A_CLRL:   reg_rdata = 32'(en_l);
         default:         reg_rdata = '0;
      endcase
   end

   p_fiq_needs_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> fiq_q[7]);
   p_irq_has_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (summary[20:0] != '0));
   p_summary_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      summary[31:21] == '0);
endmodule

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/100ps
module banked_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  src_local = '0;
   logic [31:0] src_bank1 = '0, src_bank2 = '0;
   logic [7:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o, fiq_o;
   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   banked_irq_ctrl uut (.*);

   // {local, bank1, bank2, expected summary}; all enables on, no FIQ
   localparam logic [103:0] VEC [10] = '{
      {8'h01, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001},
      {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
      {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
      {8'h00, 32'h0008_0008, 32'h0000_0000, 32'h0000_4100},
      {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
      {8'h00, 32'h0000_0000, 32'h8000_0000, 32'h0000_0200},
      {8'h00, 32'h0000_0000, 32'h0220_0000, 32'h0008_8000},
      {8'h80, 32'h0004_0600, 32'h0000_0000, 32'h0000_3880},
      {8'h00, 32'h0000_0000, 32'h01C0_0000, 32'h0007_0000},
      {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9: reset state
      rd(8'h10, d); check("R9 bank1 enable", d, 0);
      rd(8'h18, d); check("R9 local enable", d, 0);
      rd(8'h0C, d); check("R9 fiq ctrl", d, 0);
      check("R9 outputs", {30'd0, irq_o, fiq_o}, 0);

      // R3: inputs high but disabled
      src_bank1 = 32'h0000_0021; settle();
      rd(8'h04, d); check("R3 disabled masks", d, 0);
      check("R7 disabled no irq", {31'd0, irq_o}, 0);

      // R1/R2: set and clear semantics
      wr(8'h10, 32'h0000_0020);
      rd(8'h10, d); check("R2 set bit5", d, 32'h20);
      rd(8'h1C, d); check("R1 clear addr readback", d, 32'h20);
      rd(8'h04, d); check("R3 enabled bit5 pending", d, 32'h20);
      wr(8'h10, 32'h0000_0001);
      rd(8'h10, d); check("R2 zeros keep", d, 32'h21);
      wr(8'h1C, 32'h0000_0020);
      rd(8'h10, d); check("R2 clear bit5", d, 32'h01);
      rd(8'h30, d); check("R1 unmapped", d, 0);
      wr(8'h1C, 32'hFFFF_FFFF);
      src_bank1 = '0;

      // enable everything
      wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'h0000_00FF);
      rd(8'h18, d); check("R1 local enable readback", d, 32'hFF);
      rd(8'h24, d); check("R1 local clear readback", d, 32'hFF);

      // table walk: R4, R5, R6, R3, R7
      for (int i = 0; i < 10; i++) begin
         src_local = VEC[i][103:96]; src_bank1 = VEC[i][95:64]; src_bank2 = VEC[i][63:32];
         settle();
         rd(8'h00, d); check("R4/R5/R6 summary", d, VEC[i][31:0]);
         rd(8'h04, d); check("R3 bank1 pending", d, VEC[i][95:64]);
         rd(8'h08, d); check("R3 bank2 pending", d, VEC[i][63:32]);
         check("R7 irq", {31'd0, irq_o}, {31'd0, VEC[i][31:0] != 0});
      end

      // R10: two-edge latency and level clear
      @(negedge clk); src_bank2 = 32'h0000_0004;
      @(negedge clk); reg_addr = 8'h08; #1 check("R10 after one edge", reg_rdata, 0);
      @(negedge clk); #1 check("R10 after two edges", reg_rdata, 32'h4);
      src_bank2 = '0; settle();
      rd(8'h08, d); check("R10 clears on deassert", d, 0);

      // R8: FIQ routing
      src_local = 8'h04; settle();
      wr(8'h0C, 32'h82);
      #1 check("R8 fiq local2", {30'd0, irq_o, fiq_o}, 2'b01);
      rd(8'h0C, d); check("R8 readback", d, 32'h82);
      src_local = 8'h00; src_bank2 = 32'h20; settle();
      wr(8'h0C, 32'h80 | 45);
      #1 check("R8 fiq bank2 bit5", {30'd0, irq_o, fiq_o}, 2'b01);
      src_local = 8'h01; settle();
      check("R7 other source irq", {30'd0, irq_o, fiq_o}, 2'b11);
      wr(8'h0C, 32'hC8);
      #1 check("R8 index 72 picks none", {30'd0, irq_o, fiq_o}, 2'b10);
      wr(8'h0C, 32'h02); src_local = 8'h04; settle();
      check("R8 routing off", {30'd0, irq_o, fiq_o}, 2'b10);

      // R7: clearing enable removes irq
      src_bank2 = '0; src_local = '0; src_bank1 = 32'h0000_0100; settle();
      check("R7 pending irq", {31'd0, irq_o}, 1);
      wr(8'h1C, 32'h0000_0100);
      #1 check("R7 disabled drops irq", {31'd0, irq_o}, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule